// File: doc/BRIEF.md
# Programmable-Rate System Counter

This block holds one 64-bit count that several timers read at once. On each clock cycle where counting is allowed, the count grows by an increment word. That word comes from a small table of rate entries, so the count can advance by more than one per cycle. Software works through a simple register port with a valid strobe and a write strobe. Through it, software starts and stops counting, can hold the count while a debug halt is present, and can overwrite either 32-bit half of the count. Software can also edit the rate table.

To change rate, software writes a table index into a field of the control word. The block takes the request and moves the new rate into use one cycle later. The accepted index then shows in a field of the status word. In the same cycle, a one-cycle pulse tells the timers downstream that the counting speed has changed.

Top module: `syscount_top`

## Requirements
- R1: After reset the count is 0, the speed pulse is low, and the control, scale and status words read 0. Rate entry 0 reads 1, all other entries read 0, and the active index is 0.
- R2: While control bit 0 (run) is 1, the count adds the active rate entry at each clock edge. While it is 0, the count holds.
- R3: While control bit 1 (debug-halt enable) is 1 and `dbg_halt_i` is high, the count holds. While bit 1 is 0, `dbg_halt_i` has no effect.
- R4: A write to offset 0x08 replaces count bits [31:0] and a write to offset 0x0C replaces bits [63:32]. The other half keeps its value. A load takes priority over that cycle's increment, and the new value shows after the write's clock edge.
- R5: Reads at 0x08 and 0x0C return the low and high halves of the live count.
- R6: A control write with a table index in bits [17:8] is accepted when that entry is nonzero and differs from the active index. The index is accepted at the write's clock edge. At the next edge, the status field bits [31:8] take the index, the increment switches to that entry, and `speed_chg_o` goes high for exactly one cycle.
- R7: A request whose entry is zero, whose index lies outside the table, or whose index equals the active one is ignored. The status field, the increment and `speed_chg_o` do not change.
- R8: Rate entry i reads and writes as a 32-bit word at offset 0x20+4*i.
- R9: Offset 0x10 is a read/write 32-bit scale word. Control bits [2:0] and [17:8] read back. Offset 0x1C reads the number of table entries. Status bits [7:0] read 0.
- R10: A read of any unmapped or misaligned offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the strobe |
| dbg_halt_i | input | 1 | Debug halt request |
| count_o | output | 64 | Live count |
| speed_chg_o | output | 1 | One-cycle pulse when the increment changes |

## Verification
The assertions assume that a write never hits both count halves in one cycle, which the single-address port already guarantees. They also assume that the write strobe is sampled only at clock edges. The bench therefore changes the bus and `dbg_halt_i` only on falling edges, and issues at most one access per cycle. The bench does not zero the active rate entry while it is counting, so each increment value it predicts stays well defined.

// File: rtl/syscount_pkg.sv
package syscount_pkg;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned IDX_LSB = 8;
  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_STAT   = 8'h04;
  localparam logic [7:0] A_CNT_LO = 8'h08;
  localparam logic [7:0] A_CNT_HI = 8'h0C;
  localparam logic [7:0] A_SCALE  = 8'h10;
  localparam logic [7:0] A_IDENT  = 8'h1C;
  localparam logic [7:0] A_FTAB   = 8'h20;

  typedef struct packed {
    logic [IDX_W-1:0] req_idx;
    logic             scale_en;
    logic             halt_en;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/syscount_rstsync.sv
module syscount_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/syscount_freq.sv
module syscount_freq #(
  parameter int unsigned NUM_FREQ = 4,
  parameter int unsigned IDX_W    = 10,
  parameter int unsigned RATE_W   = 32,
  localparam int unsigned SEL_W   = (NUM_FREQ > 1) ? $clog2(NUM_FREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tab_we,
  input  logic [SEL_W-1:0]  tab_sel,
  input  logic [RATE_W-1:0] tab_wdata,
  output logic [RATE_W-1:0] tab_rdata,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_idx,
  output logic [IDX_W-1:0]  active_idx_o,
  output logic [RATE_W-1:0] incr_o,
  output logic              speed_chg_o
);
  logic [RATE_W-1:0] tab_q [NUM_FREQ];
  logic [RATE_W-1:0] req_rate;
  logic              req_ok;
  logic              pend_q, pend_d;
  logic [IDX_W-1:0]  pend_idx_q, pend_idx_d;
  logic [IDX_W-1:0]  active_q, active_d;
  logic              chg_q, chg_d;

  for (genvar i = 0; i < NUM_FREQ; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab_q[i] <= (i == 0) ? RATE_W'(1) : '0;
      else if (tab_we && tab_sel == SEL_W'(i)) tab_q[i] <= tab_wdata;
    end
  end

  always_comb begin
    req_rate  = '0;
    incr_o    = '0;
    tab_rdata = '0;
    for (int i = 0; i < NUM_FREQ; i++) begin
      if (req_idx == IDX_W'(i))    req_rate  = tab_q[i];
      if (active_q == IDX_W'(i))   incr_o    = tab_q[i];
      if (tab_sel == SEL_W'(i))    tab_rdata = tab_q[i];
    end
  end

  assign req_ok = req_valid && (req_rate != '0) && (req_idx != active_q)
                  && !(pend_q && req_idx == pend_idx_q);

  always_comb begin
    pend_d     = req_ok;
    pend_idx_d = req_ok ? req_idx : pend_idx_q;
    active_d   = pend_q ? pend_idx_q : active_q;
    chg_d      = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      active_q   <= '0;
      chg_q      <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      pend_idx_q <= pend_idx_d;
      active_q   <= active_d;
      chg_q      <= chg_d;
    end
  end

  assign active_idx_o = active_q;
  assign speed_chg_o  = chg_q;

  assert_ack_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_q |-> active_q == $past(active_q));
  assert_ack_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> active_q != $past(active_q));
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rate == '0) |=> !pend_q);
endmodule

// File: rtl/syscount_accum.sv
module syscount_accum #(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned RATE_W = 32,
  localparam int unsigned HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              ld_lo_i,
  input  logic              ld_hi_i,
  input  logic [HALF_W-1:0] ld_data_i,
  input  logic [RATE_W-1:0] incr_i,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = run_i | ld_lo_i | ld_hi_i;

  always_comb begin
    cnt_d = cnt_q;
    if (ld_lo_i)      cnt_d[HALF_W-1:0]     = ld_data_i;
    else if (ld_hi_i) cnt_d[CNT_W-1:HALF_W] = ld_data_i;
    else              cnt_d = cnt_q + CNT_W'(incr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ld_lo_i && !ld_hi_i) |=> count_o == $past(count_o));
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ld_lo_i && !ld_hi_i) |=> count_o == $past(count_o) + CNT_W'($past(incr_i)));
  assert_load_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> count_o[HALF_W-1:0] == $past(ld_data_i)
               && count_o[CNT_W-1:HALF_W] == $past(count_o[CNT_W-1:HALF_W]));
  assert_load_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hi_i && !ld_lo_i) |=> count_o[CNT_W-1:HALF_W] == $past(ld_data_i)
               && count_o[HALF_W-1:0] == $past(count_o[HALF_W-1:0]));
endmodule

// File: rtl/syscount_top.sv
module syscount_top
  import syscount_pkg::*;
#(
  parameter int unsigned NUM_FREQ = 4,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 64,
  localparam int unsigned SEL_W   = (NUM_FREQ > 1) ? $clog2(NUM_FREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              dbg_halt_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              speed_chg_o
);
  localparam int unsigned HALF_W = CNT_W / 2;

  logic              rst_sync_n;
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] scale_q;
  logic              wr, wr_ctrl, wr_scale, wr_lo, wr_hi, wr_tab, in_tab;
  logic [ADDR_W-1:0] tab_off;
  logic [SEL_W-1:0]  tab_sel;
  logic [DATA_W-1:0] tab_rdata, incr;
  logic [IDX_W-1:0]  active_idx;
  logic              run;

  syscount_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign wr       = bus_valid_i && bus_write_i;
  assign wr_ctrl  = wr && bus_addr_i == ADDR_W'(A_CTRL);
  assign wr_scale = wr && bus_addr_i == ADDR_W'(A_SCALE);
  assign wr_lo    = wr && bus_addr_i == ADDR_W'(A_CNT_LO);
  assign wr_hi    = wr && bus_addr_i == ADDR_W'(A_CNT_HI);
  assign tab_off  = bus_addr_i - ADDR_W'(A_FTAB);
  assign in_tab   = (tab_off[1:0] == 2'b00) && (tab_off < ADDR_W'(4 * NUM_FREQ));
  assign tab_sel  = tab_off[SEL_W+1:2];
  assign wr_tab   = wr && in_tab;

  assign ctrl_d = ctrl_t'{req_idx:  bus_wdata_i[IDX_LSB +: IDX_W],
                          scale_en: bus_wdata_i[2],
                          halt_en:  bus_wdata_i[1],
                          run:      bus_wdata_i[0]};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      scale_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_d;
      if (wr_scale) scale_q <= bus_wdata_i;
    end
  end

  assign run = ctrl_q.run && !(ctrl_q.halt_en && dbg_halt_i);

  syscount_freq #(.NUM_FREQ(NUM_FREQ), .IDX_W(IDX_W), .RATE_W(DATA_W)) u_freq (
    .clk(clk), .rst_n(rst_sync_n),
    .tab_we(wr_tab), .tab_sel(tab_sel), .tab_wdata(bus_wdata_i), .tab_rdata(tab_rdata),
    .req_valid(wr_ctrl), .req_idx(bus_wdata_i[IDX_LSB +: IDX_W]),
    .active_idx_o(active_idx), .incr_o(incr), .speed_chg_o(speed_chg_o));

  syscount_accum #(.CNT_W(CNT_W), .RATE_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run),
    .ld_lo_i(wr_lo), .ld_hi_i(wr_hi), .ld_data_i(bus_wdata_i[HALF_W-1:0]),
    .incr_i(incr), .count_o(count_o));

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      if (bus_addr_i == ADDR_W'(A_CTRL))
        bus_rdata_o = DATA_W'({ctrl_q.req_idx, 5'b0, ctrl_q.scale_en, ctrl_q.halt_en, ctrl_q.run});
      else if (bus_addr_i == ADDR_W'(A_STAT))
        bus_rdata_o = DATA_W'({active_idx, 8'b0});
      else if (bus_addr_i == ADDR_W'(A_CNT_LO)) bus_rdata_o = count_o[HALF_W-1:0];
      else if (bus_addr_i == ADDR_W'(A_CNT_HI)) bus_rdata_o = count_o[CNT_W-1:HALF_W];
      else if (bus_addr_i == ADDR_W'(A_SCALE))  bus_rdata_o = scale_q;
      else if (bus_addr_i == ADDR_W'(A_IDENT))  bus_rdata_o = DATA_W'(NUM_FREQ);
      else if (in_tab)                          bus_rdata_o = tab_rdata;
    end
  end

  assert_halt_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_q.halt_en && dbg_halt_i && !wr_lo && !wr_hi) |=> count_o == $past(count_o));
endmodule

// File: tb/sim_syscount_top.sv
module sim_syscount_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0, dbg_halt_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [63:0] count_o;
  logic        speed_chg_o;
  int checks = 0, errors = 0, pulses = 0;

  always #10 clk = ~clk;

  syscount_top u0 (.clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid_i),
    .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .dbg_halt_i(dbg_halt_i), .count_o(count_o),
    .speed_chg_o(speed_chg_o));

  always @(negedge clk) if (speed_chg_o) pulses++;

  // {1 = write / 0 = read-check, offset, data or expected}
  localparam logic [40:0] VEC [12] = '{
    {1'b1, 8'h24, 32'h3}, {1'b0, 8'h24, 32'h3},
    {1'b1, 8'h28, 32'h10}, {1'b0, 8'h28, 32'h10},
    {1'b1, 8'h10, 32'hA5A5_0F0F}, {1'b0, 8'h10, 32'hA5A5_0F0F},
    {1'b0, 8'h1C, 32'h4}, {1'b0, 8'h30, 32'h0},
    {1'b0, 8'h04, 32'h0}, {1'b0, 8'h20, 32'h1},
    {1'b1, 8'h2C, 32'h0}, {1'b0, 8'h2C, 32'h0}};

  function automatic string vec_req(input logic [7:0] a);
    if (a == 8'h10 || a == 8'h1C || a == 8'h04) return "R9";
    if (a == 8'h30) return "R10";
    return "R8";
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid_i = 1'b1; bus_write_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 1'b0; bus_write_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = a;
    #1;
    chk(req, {32'b0, bus_rdata_o}, {32'b0, exp});
    bus_valid_i = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] c;
    int p;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    chk("R1", count_o, 64'h0);
    chk("R1", {63'b0, speed_chg_o}, 64'h0);
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", 8'h04, 32'h0);
    rd_chk("R1", 8'h10, 32'h0);
    rd_chk("R1", 8'h20, 32'h1);
    rd_chk("R1", 8'h24, 32'h0);

    for (int i = 0; i < 12; i++) begin
      if (VEC[i][40]) bus_wr(VEC[i][39:32], VEC[i][31:0]);
      else rd_chk(vec_req(VEC[i][39:32]), VEC[i][39:32], VEC[i][31:0]);
    end
    rd_chk("R10", 8'h22, 32'h0);
    rd_chk("R10", 8'h14, 32'h0);

    // R2 run and hold
    bus_wr(8'h00, 32'h1);
    chk("R2", count_o, 64'd0);
    cyc(10);
    chk("R2", count_o, 64'd10);
    rd_chk("R5", 8'h08, 32'd10);
    rd_chk("R5", 8'h0C, 32'd0);
    bus_wr(8'h00, 32'h0);
    chk("R2", count_o, 64'd11);
    cyc(5);
    chk("R2", count_o, 64'd11);

    // R4 loads and carry
    bus_wr(8'h08, 32'hFFFF_FFF0);
    chk("R4", count_o, 64'h0000_0000_FFFF_FFF0);
    bus_wr(8'h0C, 32'h12);
    chk("R4", count_o, 64'h0000_0012_FFFF_FFF0);
    bus_wr(8'h00, 32'h1);
    cyc(20);
    chk("R2", count_o, 64'h0000_0013_0000_0004);
    c = count_o;
    bus_wr(8'h0C, 32'h5);
    chk("R4", count_o, {32'h5, c[31:0]});
    cyc(1);
    chk("R4", count_o, {32'h5, c[31:0]} + 64'd1);
    rd_chk("R5", 8'h0C, 32'h5);

    // R6 switch to entry 1 (rate 3)
    c = count_o; p = pulses;
    bus_wr(8'h00, 32'h101);
    chk("R6", count_o, c + 1);
    chk("R6", {63'b0, speed_chg_o}, 64'h0);
    rd_chk("R6", 8'h04, 32'h0);
    cyc(1);
    chk("R6", {63'b0, speed_chg_o}, 64'h1);
    rd_chk("R6", 8'h04, 32'h100);
    chk("R6", count_o, c + 2);
    cyc(1);
    chk("R6", {63'b0, speed_chg_o}, 64'h0);
    chk("R6", count_o, c + 5);
    chk("R6", pulses - p, 1);

    // R7 zero entry, out of range, same index
    p = pulses; c = count_o;
    bus_wr(8'h00, 32'h301);
    cyc(2);
    bus_wr(8'h00, 32'h901);
    cyc(2);
    bus_wr(8'h00, 32'h101);
    cyc(2);
    chk("R7", pulses - p, 0);
    chk("R7", count_o, c + 64'd27);
    rd_chk("R7", 8'h04, 32'h100);
    rd_chk("R9", 8'h00, 32'h101);

    // R6 switch to entry 2 (rate 0x10)
    c = count_o;
    bus_wr(8'h00, 32'h201);
    cyc(1);
    chk("R6", {63'b0, speed_chg_o}, 64'h1);
    chk("R6", count_o, c + 6);
    cyc(1);
    chk("R6", count_o, c + 6 + 64'h10);
    rd_chk("R6", 8'h04, 32'h200);

    // R3 debug halt
    dbg_halt_i = 1'b1;
    c = count_o;
    bus_wr(8'h00, 32'h203);
    chk("R3", count_o, c + 64'h10);
    cyc(4);
    chk("R3", count_o, c + 64'h10);
    rd_chk("R9", 8'h00, 32'h203);
    bus_wr(8'h00, 32'h201);
    chk("R3", count_o, c + 64'h10);
    cyc(3);
    chk("R3", count_o, c + 64'h40);
    dbg_halt_i = 1'b0;

    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    chk("R1", count_o, 64'h0);
    chk("R1", {63'b0, speed_chg_o}, 64'h0);
    cyc(1);
    rst_n = 1'b1;
    cyc(4);
    chk("R1", count_o, 64'h0);
    rd_chk("R1", 8'h04, 32'h0);
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", 8'h24, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule